// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a memory-mapped SPI master. Software sets it up through a 32-bit register interface. It pushes bytes into a transmit queue and pops the bytes that were received from a receive queue. Both queues are 128 bytes deep. A serial engine takes one byte at a time from the transmit queue. It shifts that byte out most-significant bit first and shifts one byte in from `miso` at the same time. The received byte goes into the receive queue. The serial clock runs at the reference clock divided by a power of two. Its idle level and its sampling edge follow the CPOL/CPHA settings.

Transfers start automatically when three things hold: the controller enable bit is set, the master bit is set, and the transmit queue is not empty. Up to three slave selects come from a four-bit active-low field in the control register, decoded by priority. A sticky/live status register, a set/clear interrupt mask and one level interrupt report the queue conditions. An optional idle gap, counted in reference cycles, can be placed between consecutive bytes.

The register offsets are fixed as follows:
- control 0x00
- status 0x04
- mask-set 0x08
- mask-clear 0x0C
- mask view 0x10
- enable 0x14
- gap 0x18
- transmit 0x1C
- receive 0x20

Top module: `spi_regmaster`

## Requirements
- R1: After reset:
  - control (0x00) reads 0x0000_3C00;
  - status (0x04) reads 0x0000_0004;
  - the mask view (0x10) reads 0;
  - `ssN` is 3'b111, `sclk` is 0 and `irq` is 0.
- R2: Control bits 13:10 form an active-low select field, decoded by priority. Bit 10 low drives `ssN[0]` low. Otherwise bits 10 and 11 equal to 1 and 0 drive `ssN[1]` low. Otherwise bits 10 and 11 equal to 1 and 1 with bit 12 low drive `ssN[2]` low. In every other case all selects stay high, and at most one select is ever low.
- R3: With control bits 5:3 equal to n, consecutive `sclk` edges within a byte are 2^n reference cycles apart. One serial clock period is therefore 2^(n+1) reference cycles.
- R4: While idle, `sclk` rests at control bit 1 (CPOL). With control bit 2 (CPHA) at 0, `mosi` is valid at the first edge of each bit. With CPHA at 1, it is valid at the second edge. Bits are sent most-significant first.
- R5: Every transmitted byte produces one received byte. That byte is assembled from `miso`, sampled on the same edges as `mosi` is valid, most-significant bit first.
- R6: A byte starts only when enable bit 0 (0x14) and control bit 0 (master) are both 1. Clearing either one aborts a byte in progress and returns `sclk` to its idle level.
- R7: A write to 0x1C pushes bits 7:0 into the 128-entry transmit queue. When the queue is full, the write is dropped and sticky status bit 0 is set. Status bit 3 is "transmit full" and bit 2 is "transmit not full".
- R8: A read of 0x20 pops the oldest received byte, or returns 0 when the receive queue is empty. Status bit 4 is "receive not empty" and bit 5 is "receive full". A received byte arriving at a full queue is dropped and sets sticky status bit 6.
- R9: Sticky status bit 1 is set each time a byte completes. Writing ones to status clears sticky bits 0, 1 and 6.
- R10: Writing ones to 0x08 sets mask bits and writing ones to 0x0C clears them. 0x10 reads the mask and ignores writes. `irq` is the OR of status bits 6:0 ANDed with the mask.
- R11: Gap bits 7:0 (0x18) insert exactly that many reference cycles of idle time after each byte, before the next byte can start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on `addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 3 | Active-low slave selects |
| irq | output | 1 | Level interrupt |

## Verification
The hardest conditions to reach from the ports are a full receive queue together with a dropped received byte. Reaching them means loading 128 transmit bytes while the engine is held off, overflowing the transmit queue by one, and then letting everything drain into a receive queue that nobody reads. A loopback from `mosi` to `miso`, optionally inverted, gives a known received value for every mode. An edge recorder in the bench checks the bit order, the sampling edge and the edge spacing independently of the received data. The effect of the gap register is measured as the difference in edge-to-edge time between a run with the gap at zero and a run with a non-zero gap.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

  localparam int BAUD_W  = 3;
  localparam int DIV_W   = (1 << BAUD_W) - 1;
  localparam int CS_W    = 4;
  localparam int GAP_W   = 8;
  localparam int IRQ_W   = 7;
  localparam int BYTE_W  = 8;

  localparam logic [5:0] A_CTRL  = 6'h00;
  localparam logic [5:0] A_STAT  = 6'h04;
  localparam logic [5:0] A_MSET  = 6'h08;
  localparam logic [5:0] A_MCLR  = 6'h0C;
  localparam logic [5:0] A_MASK  = 6'h10;
  localparam logic [5:0] A_ENA   = 6'h14;
  localparam logic [5:0] A_GAP   = 6'h18;
  localparam logic [5:0] A_TXD   = 6'h1C;
  localparam logic [5:0] A_RXD   = 6'h20;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txByte;
  } strobe_t;

  // static configuration from control to datapath
  typedef struct packed {
    logic              run;
    logic              cpol;
    logic              cpha;
    logic [BAUD_W-1:0] baud;
    logic [GAP_W-1:0]  gap;
    logic [CS_W-1:0]   csSel;
  } cfg_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic              txFull;
    logic              txEmpty;
    logic              rxFull;
    logic              rxEmpty;
    logic              byteDone;
    logic              rxDrop;
    logic [BYTE_W-1:0] rxHead;
  } dpStat_t;

endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);

  // R8
  fifo_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_rm_datapath.sv
module spi_rm_datapath
  import spi_rm_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int NUM_SS     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  cfg_t              cfg,
  input  logic              miso,
  output dpStat_t           st,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_SS-1:0] ssN
);
  localparam int EDGE_W = $clog2(2 * BYTE_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

  engState_t         state;
  logic [DIV_W-1:0]  divCnt, halfLast;
  logic [EDGE_W-1:0] edgeIdx;
  logic              tog, mosiReg;
  logic [BYTE_W-1:0] txSh, rxSh, txHead, rxByte;
  logic [GAP_W-1:0]  gapCnt;
  logic              txFull, txEmpty, rxFull, rxEmpty;
  logic              startNow, edgeNow, leading, sampleNow, shiftNow, lastEdge;

  spi_rm_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .din(stb.txByte),
    .pop(startNow), .dout(txHead), .full(txFull), .empty(txEmpty));

  spi_rm_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .push(lastEdge), .din(rxByte),
    .pop(stb.rxPop), .dout(st.rxHead), .full(rxFull), .empty(rxEmpty));

  assign halfLast  = DIV_W'((32'd1 << cfg.baud) - 32'd1);
  assign startNow  = (state == ENG_IDLE) && cfg.run && !txEmpty;
  assign edgeNow   = (state == ENG_SHIFT) && cfg.run && (divCnt == halfLast);
  assign leading   = !edgeIdx[0];
  assign sampleNow = edgeNow && (leading ^ cfg.cpha);
  assign shiftNow  = edgeNow && !(leading ^ cfg.cpha) && (edgeIdx != LAST_EDGE);
  assign lastEdge  = edgeNow && (edgeIdx == LAST_EDGE);
  assign rxByte    = cfg.cpha ? {rxSh[BYTE_W-2:0], miso} : rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ENG_IDLE;
      divCnt  <= '0;
      edgeIdx <= '0;
      tog     <= 1'b0;
      mosiReg <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      gapCnt  <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (startNow) begin
            state   <= ENG_SHIFT;
            divCnt  <= '0;
            edgeIdx <= '0;
            tog     <= 1'b0;
            mosiReg <= txHead[BYTE_W-1];
            txSh    <= cfg.cpha ? txHead : {txHead[BYTE_W-2:0], 1'b0};
          end
        end
        ENG_SHIFT: begin
          if (!cfg.run) begin
            state <= ENG_IDLE;
            tog   <= 1'b0;
          end else if (edgeNow) begin
            divCnt  <= '0;
            tog     <= !tog;
            edgeIdx <= edgeIdx + 1'b1;
            if (sampleNow) rxSh <= {rxSh[BYTE_W-2:0], miso};
            if (shiftNow) begin
              mosiReg <= txSh[BYTE_W-1];
              txSh    <= {txSh[BYTE_W-2:0], 1'b0};
            end
            if (lastEdge) begin
              if (cfg.gap != '0) begin
                state  <= ENG_GAP;
                gapCnt <= cfg.gap - 1'b1;
              end else begin
                state <= ENG_IDLE;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ENG_GAP: begin
          if (!cfg.run || gapCnt == '0) state <= ENG_IDLE;
          else gapCnt <= gapCnt - 1'b1;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign sclk = cfg.cpol ^ tog;
  assign mosi = mosiReg;

  // priority decode of the active-low select field
  for (genvar k = 0; k < NUM_SS; k++) begin : g_ss
    if (k == 0) begin : g_first
      assign ssN[k] = cfg.csSel[0];
    end else begin : g_rest
      assign ssN[k] = !(!cfg.csSel[k] && (&cfg.csSel[k-1:0]));
    end
  end

  assign st.txFull   = txFull;
  assign st.txEmpty  = txEmpty;
  assign st.rxFull   = rxFull;
  assign st.rxEmpty  = rxEmpty;
  assign st.byteDone = lastEdge;
  assign st.rxDrop   = lastEdge && rxFull;

  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ENG_SHIFT && !cfg.run) |=> (state == ENG_IDLE));

  // R6
  no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ENG_IDLE && !cfg.run) |=> (state == ENG_IDLE));

endmodule

// File: rtl/spi_rm_ctrl.sv
module spi_rm_ctrl
  import spi_rm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  dpStat_t     dp,
  output strobe_t     stb,
  output cfg_t        cfg,
  output logic        irq
);
  logic              master, cpol, cpha, manCs, manStart, enBit;
  logic [BAUD_W-1:0] baud;
  logic [CS_W-1:0]   csSel;
  logic [GAP_W-1:0]  gapReg;
  logic [IRQ_W-1:0]  maskReg, statusVec;
  logic              txOvf, doneFlag, rxOvf;
  logic [31:0]       ctrlWord;
  logic              wrCtrl, wrStat, wrMset, wrMclr, wrEna, wrGap;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrStat = wrEn && (addr == A_STAT);
  assign wrMset = wrEn && (addr == A_MSET);
  assign wrMclr = wrEn && (addr == A_MCLR);
  assign wrEna  = wrEn && (addr == A_ENA);
  assign wrGap  = wrEn && (addr == A_GAP);

  assign stb.txPush = wrEn && (addr == A_TXD);
  assign stb.txByte = wdata[BYTE_W-1:0];
  assign stb.rxPop  = rdEn && (addr == A_RXD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      master   <= 1'b0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      baud     <= '0;
      csSel    <= '1;
      manCs    <= 1'b0;
      manStart <= 1'b0;
      enBit    <= 1'b0;
      gapReg   <= '0;
      maskReg  <= '0;
    end else begin
      if (wrCtrl) begin
        master   <= wdata[0];
        cpol     <= wdata[1];
        cpha     <= wdata[2];
        baud     <= wdata[5:3];
        csSel    <= wdata[13:10];
        manCs    <= wdata[14];
        manStart <= wdata[15];
      end
      if (wrEna) enBit  <= wdata[0];
      if (wrGap) gapReg <= wdata[GAP_W-1:0];
      if (wrMset) maskReg <= maskReg | wdata[IRQ_W-1:0];
      else if (wrMclr) maskReg <= maskReg & ~wdata[IRQ_W-1:0];
    end
  end

  // sticky bits: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOvf    <= 1'b0;
      doneFlag <= 1'b0;
      rxOvf    <= 1'b0;
    end else begin
      if (stb.txPush && dp.txFull) txOvf <= 1'b1;
      else if (wrStat && wdata[0]) txOvf <= 1'b0;
      if (dp.byteDone) doneFlag <= 1'b1;
      else if (wrStat && wdata[1]) doneFlag <= 1'b0;
      if (dp.rxDrop) rxOvf <= 1'b1;
      else if (wrStat && wdata[6]) rxOvf <= 1'b0;
    end
  end

  assign statusVec = {rxOvf, dp.rxFull, !dp.rxEmpty, dp.txFull, !dp.txFull, doneFlag, txOvf};
  assign irq       = |(statusVec & maskReg);
  assign ctrlWord  = {16'd0, manStart, manCs, csSel, 4'd0, baud, cpha, cpol, master};

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrlWord;
      A_STAT:  rdata = {25'd0, statusVec};
      A_MASK:  rdata = {25'd0, maskReg};
      A_ENA:   rdata = {31'd0, enBit};
      A_GAP:   rdata = {24'd0, gapReg};
      A_RXD:   rdata = dp.rxEmpty ? 32'd0 : {24'd0, dp.rxHead};
      default: rdata = 32'd0;
    endcase
  end

  assign cfg.run   = enBit && master;
  assign cfg.cpol  = cpol;
  assign cfg.cpha  = cpha;
  assign cfg.baud  = baud;
  assign cfg.gap   = gapReg;
  assign cfg.csSel = csSel;

  // R7
  txovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOvf) |-> $past(stb.txPush && dp.txFull));

  // R10
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrMclr && wdata[IRQ_W-1:0] == '1) |=> !irq);

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int NUM_SS     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [5:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ssN,
  output logic              irq
);
  strobe_t stb;
  cfg_t    cfg;
  dpStat_t dpSt;

  spi_rm_ctrl ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dp(dpSt), .stb(stb), .cfg(cfg), .irq(irq));

  spi_rm_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_SS(NUM_SS)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .miso(miso),
    .st(dpSt), .sclk(sclk), .mosi(mosi), .ssN(ssN));

  // R2
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ssN));

endmodule

// File: tb/spi_regmaster_test.sv
module spi_regmaster_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_MSET = 6'h08,
    A_MCLR = 6'h0C, A_MASK = 6'h10, A_ENA = 6'h14, A_GAP = 6'h18,
    A_TXD = 6'h1C, A_RXD = 6'h20;

  // {cpol, cpha, baud[2:0], invert, txByte[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h3C},
    {1'b1, 1'b0, 3'd2, 1'b0, 8'h81},
    {1'b1, 1'b1, 3'd0, 1'b1, 8'h7E},
    {1'b0, 1'b0, 3'd3, 1'b1, 8'h01},
    {1'b1, 1'b1, 3'd2, 1'b0, 8'hF0},
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h96},
    {1'b1, 1'b0, 3'd1, 1'b1, 8'hC3}
  };

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, miso, irq, invBit = 1'b0;
  logic [2:0]  ssN;
  logic        expCpol = 1'b0, expCpha = 1'b0;

  int  nChecks = 0, nFail = 0;
  int  edgeN = 0, capCnt = 0;
  logic [7:0] capByte = '0;
  time edgeT [64];

  assign miso = mosi ^ invBit;

  spi_regmaster uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ssN(ssN), .irq(irq));

  always #(CLK_PERIOD / 2) clk = !clk;

  // edge recorder: sole writer of the capture state
  always @(sclk) begin
    if (rstN) begin
      edgeT[edgeN % 64] = $time;
      edgeN = edgeN + 1;
      if ((sclk != expCpol) ^ expCpha) begin
        capByte = {capByte[6:0], mosi};
        capCnt  = capCnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitRx(input int limit);
    logic [31:0] s;
    for (int n = 0; n < limit; n++) begin
      busRd(A_STAT, s);
      if (s[4]) break;
    end
  endtask

  task automatic finishRun;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    logic [13:0] v;
    logic [7:0]  tx;
    logic [2:0]  bd;
    int baseN, baseC;
    time g0, gD;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(A_CTRL, r); chk("R1 ctrl", r, 32'h3C00);
    busRd(A_STAT, r); chk("R1 status", r, 32'h4);
    busRd(A_MASK, r); chk("R1 mask", r, 32'h0);
    chk("R1 ssN", {29'd0, ssN}, 32'h7);
    chk("R1 sclk", {31'd0, sclk}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 select decode
    busWr(A_CTRL, 32'h3800 | 32'h1); chk("R2 1110", {29'd0, ssN}, 32'h6);
    busWr(A_CTRL, 32'h2800 | 32'h1); chk("R2 1010", {29'd0, ssN}, 32'h6);
    busWr(A_CTRL, 32'h1400 | 32'h1); chk("R2 0101", {29'd0, ssN}, 32'h5);
    busWr(A_CTRL, 32'h2C00 | 32'h1); chk("R2 1011", {29'd0, ssN}, 32'h3);
    busWr(A_CTRL, 32'h1C00 | 32'h1); chk("R2 0111", {29'd0, ssN}, 32'h7);
    busWr(A_CTRL, 32'h3C00 | 32'h1); chk("R2 1111", {29'd0, ssN}, 32'h7);

    // R3 R4 R5 table of modes, dividers and data patterns
    for (int i = 0; i < 8; i++) begin
      v  = VEC[i];
      tx = v[7:0];
      bd = v[11:9];
      busWr(A_ENA, 32'h0);
      expCpol = v[13]; expCpha = v[12]; invBit = v[8];
      busWr(A_CTRL, 32'h3801 | (32'(bd) << 3) | (32'(v[12]) << 2) | (32'(v[13]) << 1));
      repeat (2) @(negedge clk);
      chk("R4 idle level", {31'd0, sclk}, {31'd0, v[13]});
      baseN = edgeN; baseC = capCnt;
      busWr(A_TXD, {24'd0, tx});
      busWr(A_ENA, 32'h1);
      waitRx(400);
      busRd(A_RXD, r);
      chk("R5 rx byte", r, {24'd0, tx ^ {8{v[8]}}});
      chk("R4 mosi order", {24'd0, capByte}, {24'd0, tx});
      chk("R4 sample count", 32'(capCnt - baseC), 32'd8);
      chk("R3 edge span", 32'(edgeT[(baseN + 15) % 64] - edgeT[baseN % 64]),
          32'(15 * (1 << bd) * CLK_PERIOD));
      chk("R4 back to idle", {31'd0, sclk}, {31'd0, v[13]});
    end

    // R9 byte-done flag and its clear
    busRd(A_STAT, r); chk("R9 done set", {31'd0, r[1]}, 32'h1);
    busWr(A_STAT, 32'h2);
    busRd(A_STAT, r); chk("R9 done cleared", {31'd0, r[1]}, 32'h0);

    // R6 gating by enable and master
    invBit = 1'b0; expCpol = 1'b0; expCpha = 1'b0;
    busWr(A_ENA, 32'h0);
    busWr(A_CTRL, 32'h3801);
    baseN = edgeN;
    busWr(A_TXD, 32'h5A);
    repeat (100) @(negedge clk);
    chk("R6 disabled no edges", 32'(edgeN - baseN), 32'd0);
    busWr(A_CTRL, 32'h3800);
    busWr(A_ENA, 32'h1);
    repeat (100) @(negedge clk);
    chk("R6 slave mode no edges", 32'(edgeN - baseN), 32'd0);
    busRd(A_STAT, r); chk("R6 nothing received", {31'd0, r[4]}, 32'h0);
    busWr(A_CTRL, 32'h3801);
    waitRx(100);
    busRd(A_RXD, r); chk("R6 runs once allowed", r, 32'h5A);
    // abort mid-byte with a slow clock
    busWr(A_CTRL, 32'h3839 | 32'h2);
    expCpol = 1'b1;
    repeat (2) @(negedge clk);
    busWr(A_TXD, 32'hFF);
    repeat (300) @(negedge clk);
    busWr(A_ENA, 32'h0);
    repeat (2) @(negedge clk);
    chk("R6 abort idle level", {31'd0, sclk}, 32'h1);
    baseN = edgeN;
    repeat (600) @(negedge clk);
    chk("R6 abort stays quiet", 32'(edgeN - baseN), 32'd0);
    busRd(A_STAT, r); chk("R6 aborted byte not received", {31'd0, r[4]}, 32'h0);

    // R7 transmit overflow, R8 receive empty/full/drop
    busWr(A_CTRL, 32'h3801);
    expCpol = 1'b0;
    busWr(A_STAT, 32'h43);
    for (int k = 0; k < 129; k++) busWr(A_TXD, 32'(k));
    busRd(A_STAT, r);
    chk("R7 overflow sticky", {31'd0, r[0]}, 32'h1);
    chk("R7 tx full", {31'd0, r[3]}, 32'h1);
    chk("R7 tx not full low", {31'd0, r[2]}, 32'h0);
    busWr(A_STAT, 32'h1);
    busRd(A_STAT, r); chk("R9 overflow cleared", {31'd0, r[0]}, 32'h0);
    busRd(A_RXD, r); chk("R8 empty read zero", r, 32'h0);
    busWr(A_ENA, 32'h1);
    repeat (3000) @(negedge clk);
    busRd(A_STAT, r);
    chk("R8 rx full", {31'd0, r[5]}, 32'h1);
    chk("R8 rx drop clear", {31'd0, r[6]}, 32'h0);
    busWr(A_TXD, 32'h55);
    repeat (100) @(negedge clk);
    busRd(A_STAT, r); chk("R8 rx drop sticky", {31'd0, r[6]}, 32'h1);
    busRd(A_RXD, r); chk("R8 first byte", r, 32'h0);
    busRd(A_RXD, r); chk("R8 second byte", r, 32'h1);
    for (int k = 2; k < 128; k++) busRd(A_RXD, r);
    chk("R8 last kept byte", r, 32'd127);
    busRd(A_STAT, r); chk("R8 drained", {31'd0, r[4]}, 32'h0);

    // R10 mask set/clear and interrupt
    busWr(A_MSET, 32'h2);
    busRd(A_MASK, r); chk("R10 mask set", r, 32'h2);
    chk("R10 irq from done", {31'd0, irq}, 32'h1);
    busWr(A_MASK, 32'h7F);
    busRd(A_MASK, r); chk("R10 mask read-only", r, 32'h2);
    busWr(A_STAT, 32'h2);
    chk("R10 irq after clear", {31'd0, irq}, 32'h0);
    busWr(A_MSET, 32'h44);
    chk("R10 irq from live bit", {31'd0, irq}, 32'h1);
    busWr(A_MCLR, 32'h7F);
    busRd(A_MASK, r); chk("R10 mask cleared", r, 32'h0);
    chk("R10 irq low", {31'd0, irq}, 32'h0);
    busWr(A_STAT, 32'h43);

    // R11 inter-byte gap
    busWr(A_ENA, 32'h0);
    busWr(A_GAP, 32'h0);
    busWr(A_TXD, 32'h11); busWr(A_TXD, 32'h22);
    baseN = edgeN;
    busWr(A_ENA, 32'h1);
    repeat (100) @(negedge clk);
    g0 = edgeT[(baseN + 16) % 64] - edgeT[(baseN + 15) % 64];
    busRd(A_RXD, r); chk("R11 byte a", r, 32'h11);
    busRd(A_RXD, r); chk("R11 byte b", r, 32'h22);
    busWr(A_ENA, 32'h0);
    busWr(A_GAP, 32'h9);
    busWr(A_TXD, 32'h33); busWr(A_TXD, 32'h44);
    baseN = edgeN;
    busWr(A_ENA, 32'h1);
    repeat (100) @(negedge clk);
    gD = edgeT[(baseN + 16) % 64] - edgeT[(baseN + 15) % 64];
    chk("R11 gap added", 32'(gD - g0), 32'(9 * CLK_PERIOD));
    busRd(A_RXD, r); chk("R11 byte c", r, 32'h33);

    finishRun();
  end

endmodule